// File: doc/BRIEF.md
# Bounds table walk engine

This engine serves bounds-load and bounds-store operations for a pointer-checking extension. Bounds live in memory behind a two-level table. A request carries the following:

- the operating width (wide 64-bit or narrow 32-bit);
- the privilege level of the requester;
- a user and a supervisor configuration word;
- an address-base operand and a pointer value;
- for stores, a lower and an upper bound.

The engine picks the configuration word by privilege. It uses bit-fields of the base operand to find a directory entry and reads that entry. If the entry's valid bit is clear, the walk stops with a bound fault. Otherwise the engine uses further base bits to find a three-word table entry.

A load reads the lower bound, the upper bound and the stored pointer from that entry. It returns both bounds, or zero for both if the stored pointer does not match the requested one. A store writes the two bounds and the pointer into the entry. Every memory access goes through one word-wide request/response port, with at most one access in flight.

The engine sits beside a bounds register file and an exception unit. It raises `busy` while a walk runs. It pulses `done` when the walk ends, together with `fault` if the directory entry was invalid. On a fault, a status register records the failing directory address.

Top module: `bnd_walk`

## Requirements
- R1: When `req_priv` equals 3 the user configuration word is used for the walk; at every other privilege level the supervisor word is used.
- R2: Wide mode: the directory address is base bits [47:20] shifted left by 3, plus configuration bits [63:20] shifted left by 12, modulo 2^64. It is read as an 8-byte access (`mem_req_wide`=1).
- R3: Narrow mode: the directory address is base bits [31:12] shifted left by 2, plus the low 32 configuration bits with bits [11:0] cleared, modulo 2^32. Base and configuration bits above 31 have no effect.
- R4: If bit 0 of the directory word is 0, the walk ends with `fault` and `done` both high for one cycle. `status` becomes the directory address with bit 1 set, and no table entry access is made.
- R5: Wide mode: the entry address is base bits [19:3] shifted left by 5, plus the directory word with bits [2:0] cleared. The three entry words sit at offsets 0, 8 and 16.
- R6: Narrow mode: the entry address is base bits [11:2] shifted left by 4, plus the low 32 directory bits with bits [1:0] cleared, modulo 2^32. The entry words sit at offsets 0, 4 and 8 and use 4-byte accesses (`mem_req_wide`=0). Only the low 32 bits of read data, bounds and pointers are used, and all addresses fit in 32 bits.
- R7: A load reads entry words 0, 1 and 2 in that order. If the stored pointer (word 2) equals `req_ptr`, `res_lb` and `res_ub` take words 0 and 1 when `done` pulses.
- R8: If the stored pointer differs from `req_ptr` (low 32 bits only in narrow mode), both `res_lb` and `res_ub` are 0.
- R9: A store writes `req_lb` to word 0, then `req_ub` to word 1, then `req_ptr` to word 2 (`mem_req_we`=1).
- R10: At most one memory access is in flight: a new request is issued only after the previous response. An unaccepted request holds its address and data stable.
- R11: `busy` is high from the cycle after acceptance until `done` pulses. `done` lasts one cycle. A `req_valid` seen while busy is ignored.
- R12: After reset `busy`, `done`, `fault` and `mem_req_valid` are 0, and `status`, `res_lb` and `res_ub` are 0.
- R13: `status` changes only on a fault; successful walks leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_store | input | 1 | 1 = bounds store, 0 = bounds load |
| req_mode64 | input | 1 | 1 = wide mode, 0 = narrow mode |
| req_priv | input | 2 | Privilege level of the requester |
| cfg_user | input | 64 | User configuration word |
| cfg_super | input | 64 | Supervisor configuration word |
| req_base | input | 64 | Address-base operand |
| req_ptr | input | 64 | Pointer value |
| req_lb | input | 64 | Lower bound to store |
| req_ub | input | 64 | Upper bound to store |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended on an invalid directory entry |
| res_lb | output | 64 | Loaded lower bound |
| res_ub | output | 64 | Loaded upper bound |
| status | output | 64 | Fault address status |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_wide | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| mem_req_addr | output | 64 | Memory byte address |
| mem_req_wdata | output | 64 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Memory read data |

## Verification
The bench builds the engine with its defaults: 64-bit data, a 2-bit privilege level with user level 3, and the narrow mode included. With the narrow path present, one build covers both address formulas, the 4-byte accesses, and masking of the upper 32 bits of inputs and read data. In narrow mode the memory model returns random upper bits, so any leak of those bits into addresses or results shows up. Random base operands, configuration words and privilege levels spread the walk over many directory and entry addresses. Directed cases then cover valid-bit masking, pointer mismatch, faults under each configuration, and a request arriving while busy.

// File: rtl/bnd_walk_pkg.sv
package bnd_walk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR_REQ,
      ST_DIR_WAIT,
      ST_ENT_REQ,
      ST_ENT_WAIT
   } walk_st_t;

   // wide-mode field positions
   localparam int W_DIR_LSB  = 20;
   localparam int W_DIR_W    = 28;
   localparam int W_DIR_SH   = 3;
   localparam int W_ENT_LSB  = 3;
   localparam int W_ENT_W    = 17;
   localparam int W_ENT_SH   = 5;
   localparam int W_CFG_LSB  = 20;
   localparam int W_CFG_SH   = 12;
   localparam int W_ALIGN    = 3;

   // narrow-mode field positions
   localparam int N_XLEN     = 32;
   localparam int N_DIR_LSB  = 12;
   localparam int N_DIR_W    = 20;
   localparam int N_DIR_SH   = 2;
   localparam int N_ENT_LSB  = 2;
   localparam int N_ENT_W    = 10;
   localparam int N_ENT_SH   = 4;
   localparam int N_CFG_LSB  = 12;
   localparam int N_ALIGN    = 2;

   localparam int ENTRY_WORDS = 3;
   localparam int IDX_W       = 2;

endpackage

// File: rtl/bnd_cfg_sel.sv
module bnd_cfg_sel #(
   parameter int XLEN      = 64,
   parameter int PRIV_W    = 2,
   parameter int USER_PRIV = 3
) (
   input  logic [PRIV_W-1:0] priv,
   input  logic [XLEN-1:0]   cfg_user,
   input  logic [XLEN-1:0]   cfg_super,
   output logic [XLEN-1:0]   cfg_sel
);
   localparam logic [PRIV_W-1:0] USER_CODE = PRIV_W'(USER_PRIV);

   generate
      if (USER_PRIV >= (1 << PRIV_W)) begin : g_bad_priv
         $error("bnd_cfg_sel: USER_PRIV does not fit in PRIV_W bits");
      end
   endgenerate

   always_comb begin
      cfg_sel = (priv == USER_CODE) ? cfg_user : cfg_super;
   end
endmodule

// File: rtl/bnd_addr_gen.sv
module bnd_addr_gen
   import bnd_walk_pkg::*;
#(
   parameter int XLEN           = 64,
   parameter bit SUPPORT_NARROW = 1'b1
) (
   input  logic             wide,
   input  logic [XLEN-1:0]  base,
   input  logic [XLEN-1:0]  cfg,
   input  logic [XLEN-1:0]  dir_word,
   input  logic [IDX_W-1:0] word_idx,
   output logic [XLEN-1:0]  dir_addr,
   output logic [XLEN-1:0]  ent_addr
);
   localparam int W_CFG_W = XLEN - W_CFG_LSB;

   logic [XLEN-1:0] dir_w, ent_base_w, ent_w;
   logic [XLEN-1:0] dir_n, ent_n;

   // wide path
   always_comb begin
      dir_w = (XLEN'(base[W_DIR_LSB +: W_DIR_W]) << W_DIR_SH)
            + (XLEN'(cfg[W_CFG_LSB +: W_CFG_W]) << W_CFG_SH);
      ent_base_w = (XLEN'(base[W_ENT_LSB +: W_ENT_W]) << W_ENT_SH)
                 + {dir_word[XLEN-1:W_ALIGN], {W_ALIGN{1'b0}}};
      ent_w = ent_base_w + (XLEN'(word_idx) << W_ALIGN);
   end

   // narrow path, or a copy of the wide path when narrow mode is left out
   generate
      if (SUPPORT_NARROW) begin : g_narrow
         logic [N_XLEN-1:0] dir32, ent_base32, ent32;
         always_comb begin
            dir32 = (N_XLEN'(base[N_DIR_LSB +: N_DIR_W]) << N_DIR_SH)
                  + {cfg[N_XLEN-1:N_CFG_LSB], {N_CFG_LSB{1'b0}}};
            ent_base32 = (N_XLEN'(base[N_ENT_LSB +: N_ENT_W]) << N_ENT_SH)
                       + {dir_word[N_XLEN-1:N_ALIGN], {N_ALIGN{1'b0}}};
            ent32 = ent_base32 + (N_XLEN'(word_idx) << N_ALIGN);
            dir_n = XLEN'(dir32);
            ent_n = XLEN'(ent32);
         end
      end else begin : g_wide_only
         always_comb begin
            dir_n = dir_w;
            ent_n = ent_w;
         end
      end
   endgenerate

   always_comb begin
      dir_addr = wide ? dir_w : dir_n;
      ent_addr = wide ? ent_w : ent_n;
   end
endmodule

// File: rtl/bnd_result.sv
module bnd_result #(
   parameter int XLEN = 64
) (
   input  logic            wide,
   input  logic [XLEN-1:0] raw_lb,
   input  logic [XLEN-1:0] raw_ub,
   input  logic [XLEN-1:0] ptr_stored,
   input  logic [XLEN-1:0] ptr_req,
   output logic            ptr_match,
   output logic [XLEN-1:0] out_lb,
   output logic [XLEN-1:0] out_ub
);
   localparam int HALF = 32;

   logic [XLEN-1:0] mask;

   always_comb begin
      mask      = wide ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
      ptr_match = ((ptr_stored ^ ptr_req) & mask) == '0;
      out_lb    = ptr_match ? (raw_lb & mask) : '0;
      out_ub    = ptr_match ? (raw_ub & mask) : '0;
   end
endmodule

// File: rtl/bnd_walk.sv
module bnd_walk
   import bnd_walk_pkg::*;
#(
   parameter int XLEN           = 64,
   parameter int PRIV_W         = 2,
   parameter int USER_PRIV      = 3,
   parameter bit SUPPORT_NARROW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic              req_mode64,
   input  logic [PRIV_W-1:0] req_priv,
   input  logic [XLEN-1:0]   cfg_user,
   input  logic [XLEN-1:0]   cfg_super,
   input  logic [XLEN-1:0]   req_base,
   input  logic [XLEN-1:0]   req_ptr,
   input  logic [XLEN-1:0]   req_lb,
   input  logic [XLEN-1:0]   req_ub,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic [XLEN-1:0]   res_lb,
   output logic [XLEN-1:0]   res_ub,
   output logic [XLEN-1:0]   status,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic              mem_req_wide,
   output logic [XLEN-1:0]   mem_req_addr,
   output logic [XLEN-1:0]   mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data
);
   localparam int HALF = 32;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_WORDS - 1);
   localparam logic [XLEN-1:0]  FAULT_TAG = XLEN'(2);

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("bnd_walk: table field layout requires XLEN of 64");
      end
   endgenerate

   walk_st_t         st;
   logic             op_store, op_wide;
   logic [XLEN-1:0]  base_q, ptr_q, lb_in_q, ub_in_q, cfg_q, dir_q;
   logic [XLEN-1:0]  raw_lb_q, raw_ub_q, res_lb_q, res_ub_q, status_q;
   logic [IDX_W-1:0] idx_q;
   logic             done_q, fault_q;

   logic [XLEN-1:0]  cfg_now, dir_addr, ent_addr, data_mask, rsp_m, wdata;
   logic [XLEN-1:0]  fin_lb, fin_ub;
   logic             ptr_match;
   logic             wide_now;

   bnd_cfg_sel #(.XLEN(XLEN), .PRIV_W(PRIV_W), .USER_PRIV(USER_PRIV)) u_cfg (
      .priv      (req_priv),
      .cfg_user  (cfg_user),
      .cfg_super (cfg_super),
      .cfg_sel   (cfg_now)
   );

   bnd_addr_gen #(.XLEN(XLEN), .SUPPORT_NARROW(SUPPORT_NARROW)) u_addr (
      .wide     (op_wide),
      .base     (base_q),
      .cfg      (cfg_q),
      .dir_word (dir_q),
      .word_idx (idx_q),
      .dir_addr (dir_addr),
      .ent_addr (ent_addr)
   );

   bnd_result #(.XLEN(XLEN)) u_res (
      .wide       (op_wide),
      .raw_lb     (raw_lb_q),
      .raw_ub     (raw_ub_q),
      .ptr_stored (mem_rsp_data),
      .ptr_req    (ptr_q),
      .ptr_match  (ptr_match),
      .out_lb     (fin_lb),
      .out_ub     (fin_ub)
   );

   always_comb begin
      wide_now  = SUPPORT_NARROW ? req_mode64 : 1'b1;
      data_mask = op_wide ? {XLEN{1'b1}} : {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};
      rsp_m     = mem_rsp_data & data_mask;
      case (idx_q)
         2'd0:    wdata = lb_in_q;
         2'd1:    wdata = ub_in_q;
         default: wdata = ptr_q;
      endcase
   end

   assign busy          = (st != ST_IDLE);
   assign done          = done_q;
   assign fault         = fault_q;
   assign res_lb        = res_lb_q;
   assign res_ub        = res_ub_q;
   assign status        = status_q;
   assign mem_req_valid = (st == ST_DIR_REQ) || (st == ST_ENT_REQ);
   assign mem_req_we    = (st == ST_ENT_REQ) && op_store;
   assign mem_req_wide  = op_wide;
   assign mem_req_addr  = (st == ST_DIR_REQ) ? dir_addr : ent_addr;
   assign mem_req_wdata = wdata & data_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_store <= 1'b0;
         op_wide  <= 1'b1;
         base_q   <= '0;
         ptr_q    <= '0;
         lb_in_q  <= '0;
         ub_in_q  <= '0;
         cfg_q    <= '0;
         dir_q    <= '0;
         raw_lb_q <= '0;
         raw_ub_q <= '0;
         res_lb_q <= '0;
         res_ub_q <= '0;
         status_q <= '0;
         idx_q    <= '0;
         done_q   <= 1'b0;
         fault_q  <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  op_store <= req_store;
                  op_wide  <= wide_now;
                  base_q   <= req_base;
                  ptr_q    <= req_ptr;
                  lb_in_q  <= req_lb;
                  ub_in_q  <= req_ub;
                  cfg_q    <= cfg_now;
                  idx_q    <= '0;
                  st       <= ST_DIR_REQ;
               end
            end
            ST_DIR_REQ: begin
               if (mem_req_ready) st <= ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!rsp_m[0]) begin
                     status_q <= dir_addr | FAULT_TAG;
                     fault_q  <= 1'b1;
                     done_q   <= 1'b1;
                     st       <= ST_IDLE;
                  end else begin
                     dir_q <= rsp_m;
                     idx_q <= '0;
                     st    <= ST_ENT_REQ;
                  end
               end
            end
            ST_ENT_REQ: begin
               if (mem_req_ready) st <= ST_ENT_WAIT;
            end
            ST_ENT_WAIT: begin
               if (mem_rsp_valid) begin
                  if (idx_q == 2'd0) raw_lb_q <= rsp_m;
                  if (idx_q == 2'd1) raw_ub_q <= rsp_m;
                  if (idx_q == LAST_IDX) begin
                     if (!op_store) begin
                        res_lb_q <= fin_lb;
                        res_ub_q <= fin_ub;
                     end
                     done_q <= 1'b1;
                     st     <= ST_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st    <= ST_ENT_REQ;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R4: a fault always ends the walk and tags the status word
   a_r4_fault_status: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && status[1]));

   // R11: the done pulse arrives with the engine back at idle
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11: a walk only starts from a request
   a_r11_start_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R10: a stalled request holds still
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
          && $stable(mem_req_we)));

   // R6: narrow accesses stay within 32-bit addresses
   a_r6_narrow_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_wide) |-> (mem_req_addr[XLEN-1:HALF] == '0));

   // R13: status moves only together with a fault
   a_r13_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fault |-> $stable(status));

endmodule

// File: tb/sim_bnd_walk.sv
module sim_bnd_walk;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        req_valid = 0, req_store = 0, req_mode64 = 1;
   logic [1:0]  req_priv = 0;
   logic [63:0] cfg_user = 0, cfg_super = 0, req_base = 0, req_ptr = 0, req_lb = 0, req_ub = 0;
   logic        busy, done, fault;
   logic [63:0] res_lb, res_ub, status;
   logic        mem_req_valid, mem_req_we, mem_req_wide;
   logic        mem_req_ready = 0, mem_rsp_valid = 0;
   logic [63:0] mem_req_addr, mem_req_wdata, mem_rsp_data = 0;

   bnd_walk u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_mode64(req_mode64), .req_priv(req_priv), .cfg_user(cfg_user),
      .cfg_super(cfg_super), .req_base(req_base), .req_ptr(req_ptr),
      .req_lb(req_lb), .req_ub(req_ub), .busy(busy), .done(done), .fault(fault),
      .res_lb(res_lb), .res_ub(res_ub), .status(status),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_wide(mem_req_wide),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   logic [63:0] mem [logic [63:0]];
   logic [63:0] lg_addr [16];
   logic [63:0] lg_wdata [16];
   logic        lg_we [16];
   logic        lg_wide [16];
   int          lg_n = 0;
   int          checks = 0, errors = 0, r10_viol = 0;
   logic [63:0] exp_status = 0;
   bit          finished = 0;

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [63:0] mrd(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   function automatic logic [63:0] e_dir(input logic w, input logic [63:0] b, input logic [63:0] c);
      logic [31:0] n;
      if (w) return ({36'b0, b[47:20]} << 3) + ({20'b0, c[63:20]} << 12);
      n = ({12'b0, b[31:12]} << 2) + (c[31:0] & 32'hFFFF_F000);
      return {32'b0, n};
   endfunction

   function automatic logic [63:0] e_ent(input logic w, input logic [63:0] b,
                                         input logic [63:0] bt, input int k);
      logic [31:0] n;
      if (w) return ({47'b0, b[19:3]} << 5) + (bt & ~64'h7) + 64'(k * 8);
      n = ({22'b0, b[11:2]} << 4) + (bt[31:0] & ~32'h3) + 32'(k * 4);
      return {32'b0, n};
   endfunction

   // memory model: one access in flight, random ready and response delay
   task automatic responder();
      bit          pend = 0;
      int          dly = 0;
      logic [63:0] pdata = 0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (pend && dly == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pdata;
            pend = 0;
         end else if (pend) begin
            dly--;
         end
         if (mem_req_valid && pend) r10_viol++;
         mem_req_ready = ($urandom % 4) != 0;
         if (mem_req_valid && mem_req_ready && !pend) begin
            if (lg_n < 16) begin
               lg_addr[lg_n]  = mem_req_addr;
               lg_wdata[lg_n] = mem_req_wdata;
               lg_we[lg_n]    = mem_req_we;
               lg_wide[lg_n]  = mem_req_wide;
            end
            lg_n++;
            if (mem_req_we)
               mem[mem_req_addr] = mem_req_wide ? mem_req_wdata : {32'b0, mem_req_wdata[31:0]};
            pdata = mrd(mem_req_addr);
            if (!mem_req_wide) pdata = {$urandom, pdata[31:0]};
            pend = 1;
            dly  = $urandom % 3;
         end
      end
   endtask

   task automatic run_op(input logic st, input logic w, input logic [1:0] pr,
                         input logic [63:0] b, input logic [63:0] p,
                         input logic [63:0] l, input logic [63:0] u, input bit inject);
      logic [63:0] cfg, da, bt, msk, e_lb, e_ub, e_pt, x_lb, x_ub;
      logic [63:0] ea [3];
      bit valid, match;
      int cyc, n_before;
      msk = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
      cfg = (pr == 2'd3) ? cfg_user : cfg_super;
      da  = e_dir(w, b, cfg);
      bt  = mrd(da) & msk;
      valid = bt[0];
      for (int k = 0; k < 3; k++) ea[k] = e_ent(w, b, bt, k);
      e_lb = mrd(ea[0]) & msk;
      e_ub = mrd(ea[1]) & msk;
      e_pt = mrd(ea[2]) & msk;
      match = ((e_pt ^ p) & msk) == 64'h0;
      x_lb = match ? e_lb : 64'h0;
      x_ub = match ? e_ub : 64'h0;

      @(negedge clk);
      req_store = st; req_mode64 = w; req_priv = pr; req_base = b;
      req_ptr = p; req_lb = l; req_ub = u; req_valid = 1'b1;
      lg_n = 0;
      @(negedge clk);
      req_valid = 1'b0;
      if (inject) begin
         // R11: request while busy must be ignored
         req_base = ~b; req_store = ~st; req_valid = 1'b1;
         @(negedge clk);
         req_valid = 1'b0; req_base = b; req_store = st;
      end
      cyc = 0;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      chk("R11 done pulse seen", {63'b0, done}, 64'd1);
      chk("R11 busy low at done", {63'b0, busy}, 64'd0);
      chk("R4 fault flag", {63'b0, fault}, {63'b0, !valid});
      if (!valid) begin
         exp_status = da | 64'h2;
         chk("R4 status on fault", status, exp_status);
         chk("R4 no entry access after fault", 64'(lg_n), 64'd1);
      end else begin
         chk("R13 status kept", status, exp_status);
         chk("R10 access count", 64'(lg_n), 64'd4);
      end
      chk(w ? "R2 directory address" : "R3 directory address", lg_addr[0], da);
      chk("R2 directory read is not a write", {63'b0, lg_we[0]}, 64'd0);
      chk("R6 access width", {63'b0, lg_wide[0]}, {63'b0, w});
      if (valid && lg_n == 4) begin
         for (int k = 0; k < 3; k++) begin
            chk(w ? "R5 entry address" : "R6 entry address", lg_addr[k+1], ea[k]);
            chk("R9 write flag", {63'b0, lg_we[k+1]}, {63'b0, st});
            chk("R6 entry width", {63'b0, lg_wide[k+1]}, {63'b0, w});
            if (st) chk("R9 store data order", lg_wdata[k+1],
                        ((k == 0) ? l : (k == 1) ? u : p) & msk);
         end
         if (!st) begin
            chk(match ? "R7 lower bound" : "R8 lower bound zeroed", res_lb, x_lb);
            chk(match ? "R7 upper bound" : "R8 upper bound zeroed", res_ub, x_ub);
         end
      end
      @(negedge clk);
      chk("R11 done lasts one cycle", {63'b0, done}, 64'd0);
      if (inject) begin
         n_before = lg_n;
         repeat (4) @(negedge clk);
         chk("R11 no walk from ignored request", {63'b0, busy}, 64'd0);
         chk("R11 no access from ignored request", 64'(lg_n), 64'(n_before));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] b, p, l, u, bt, da, ea;
      logic w, st;
      logic [1:0] pr;
      void'($urandom(32'h5EED_0042));
      fork responder(); join_none

      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 busy after reset", {63'b0, busy}, 64'd0);
      chk("R12 done after reset", {63'b0, done}, 64'd0);
      chk("R12 fault after reset", {63'b0, fault}, 64'd0);
      chk("R12 mem_req_valid after reset", {63'b0, mem_req_valid}, 64'd0);
      chk("R12 status after reset", status, 64'd0);
      chk("R12 res_lb after reset", res_lb, 64'd0);
      chk("R12 res_ub after reset", res_ub, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      cfg_user  = 64'h0000_1234_5670_0ABC;
      cfg_super = 64'h0000_0777_7770_0DEF;

      // wide store, matching load, mismatching load (R2 R5 R9 R7 R8)
      b = 64'h0000_7F12_3456_7898;
      mem[e_dir(1'b1, b, cfg_super)] = 64'h0000_0000_0ABC_D005;
      run_op(1'b1, 1'b1, 2'd0, b, 64'h1111_2222_3333_4444, 64'h1000, 64'h1FFF, 1'b0);
      run_op(1'b0, 1'b1, 2'd0, b, 64'h1111_2222_3333_4444, 0, 0, 1'b0);
      chk("R7 stored lower bound returned", res_lb, 64'h1000);
      run_op(1'b0, 1'b1, 2'd1, b, 64'h1111_2222_3333_4445, 0, 0, 1'b0);
      chk("R8 mismatch zero", res_ub, 64'h0);

      // narrow store and load with upper bits set (R3 R6)
      b = 64'hFFFF_FFFF_89AB_CDEF;
      mem[e_dir(1'b0, b, cfg_super)] = 64'h0000_0000_0040_2003;
      run_op(1'b1, 1'b0, 2'd2, b, 64'hAAAA_0000_CAFE_F00D,
             64'hDEAD_BEEF_0000_1000, 64'h5555_0000_0000_2000, 1'b0);
      run_op(1'b0, 1'b0, 2'd2, b, 64'h7777_0000_CAFE_F00D, 0, 0, 1'b0);
      chk("R6 narrow upper bound masked", res_ub, 64'h2000);

      // privilege selects configuration (R1); unset supervisor entry faults (R4)
      b = 64'h0000_0123_4560_0010;
      mem[e_dir(1'b1, b, cfg_user)] = 64'h0000_0000_0200_0001;
      run_op(1'b0, 1'b1, 2'd3, b, 64'h0, 0, 0, 1'b0);
      chk("R1 user config selected at level 3", lg_addr[0], e_dir(1'b1, b, cfg_user));
      run_op(1'b0, 1'b1, 2'd1, b, 64'h0, 0, 0, 1'b0);
      chk("R1 supervisor config selected at level 1", lg_addr[0], e_dir(1'b1, b, cfg_super));

      // narrow invalid directory (R4)
      b = 64'h0000_0000_0ABC_1234;
      mem[e_dir(1'b0, b, cfg_super)] = 64'hFFFF_FFFF_0000_1000;
      run_op(1'b1, 1'b0, 2'd0, b, 64'h1, 64'h2, 64'h3, 1'b0);

      // request while busy (R11)
      b = 64'h0000_7F12_3456_7898;
      run_op(1'b0, 1'b1, 2'd0, b, 64'h1111_2222_3333_4444, 0, 0, 1'b1);

      // constrained random walks
      for (int i = 0; i < 60; i++) begin
         w  = $urandom % 2;
         st = $urandom % 2;
         pr = 2'($urandom % 4);
         cfg_user  = {$urandom, $urandom};
         cfg_super = {$urandom, $urandom};
         b = {$urandom, $urandom};
         p = {$urandom, $urandom};
         l = {$urandom, $urandom};
         u = {$urandom, $urandom};
         da = e_dir(w, b, (pr == 2'd3) ? cfg_user : cfg_super);
         bt = {$urandom, $urandom};
         bt[0] = (($urandom % 8) != 0);
         mem[da] = bt;
         if (!st && bt[0] && ($urandom % 2) == 1) begin
            for (int k = 0; k < 3; k++) begin
               ea = e_ent(w, b, w ? bt : {32'b0, bt[31:0]}, k);
               mem[ea] = (k == 0) ? l : (k == 1) ? u : ((($urandom % 2) == 1) ? p : ~p);
            end
         end
         run_op(st, w, pr, b, p, l, u, (i % 10) == 3);
      end

      chk("R10 no request while response pending", 64'(r10_viol), 64'd0);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule